// File: doc/BRIEF.md
# Fall-Through Bubble FIFO

This block is a first-in first-out buffer made of a chain of word stages rather than an addressed memory with pointers. It holds 16 words of 4 bits by default. Each stage has one data word and an occupancy marker. On every clock, a stage whose marker is clear takes the word from the stage before it when that stage's marker is set. Valid words therefore move toward the output end, and empty slots move back toward the input end. Word order is kept.

The producer watches the input-ready flag. It presents a word and raises the shift-in strobe. The strobe must drop before the block accepts another word. The consumer watches the output-ready flag and reads the output word. A rising edge on the shift-out strobe removes that word. The output word appears on the port only while output enable is high, and an enable indication goes with it. Both strobes are sampled on the system clock, and their edges are detected on that clock. A synchronous master reset clears every marker.

Top module: `bubble_fifo`

## Requirements
- R1: After a clock edge with rst high, in_rdy is 1 and out_rdy is 0.
- R2: A word on din is taken only on a clock where shin is high and was low at the previous clock, and in_rdy is high. Holding shin high for several clocks stores a single word.
- R3: After a word is accepted, in_rdy is low for the next cycle. When the second stage is empty, in_rdy is high again one cycle later.
- R4: A word accepted into an empty buffer raises out_rdy 15 clocks after the clock that accepted it, not earlier.
- R5: Words leave in the order they entered. The output word and out_rdy stay unchanged until that word is removed.
- R6: The buffer takes exactly 16 words. While it is full, in_rdy stays low and shin edges store nothing and corrupt nothing.
- R7: A shout rising edge while out_rdy is high removes the output word, so out_rdy is low in the next cycle. A waiting word refills the output stage one clock later.
- R8: A shout rising edge while out_rdy is low has no effect, and no later word is lost to it.
- R9: When oe is high, dout carries the output-stage word. When oe is low, dout is 0. dout_en equals oe.
- R10: Asserting rst while words are held discards all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous master reset, active high |
| shin | input | 1 | Shift-in strobe, rising edge stores din |
| din | input | 4 | Input data word |
| in_rdy | output | 1 | Input stage empty |
| shout | input | 1 | Shift-out strobe, rising edge removes the output word |
| oe | input | 1 | Output enable for dout |
| dout | output | 4 | Output-stage word, 0 when oe is low |
| dout_en | output | 1 | dout is being driven |
| out_rdy | output | 1 | Output stage holds a valid word |

## Verification
The effect of a wrong marker bit depends on where it sits in the chain. A stuck or lost marker in the middle shows up at the ports only after the fall-through time. It appears as a late or missing out_rdy, a word out of order, or a missing word, up to 15 clocks after the fault. A fault in the first or last stage shows at once: in the next cycle's in_rdy, or in out_rdy after a shift-out edge. The bench therefore checks the exact fall-through cycle and drains full buffers word by word. It also checks the flags in the cycle right after each strobe edge.

// File: rtl/bubble_fifo.sv
module bubble_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shin,
  input  logic [WIDTH-1:0] din,
  output logic             in_rdy,
  input  logic             shout,
  input  logic             oe,
  output logic [WIDTH-1:0] dout,
  output logic             dout_en,
  output logic             out_rdy
);
  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0]            mark;
  logic [DEPTH-1:0][WIDTH-1:0] word;
  logic [DEPTH-1:0][WIDTH-1:0] feed;
  logic [DEPTH-1:0]            move;
  logic [DEPTH-1:0]            clear;
  logic                        shin_q, shout_q;
  logic                        load, pop;

  assign load = shin & ~shin_q & ~mark[0];
  assign pop  = shout & ~shout_q & mark[LAST];

  assign move[0]     = load;
  assign feed[0]     = din;
  assign clear[LAST] = pop;

  genvar i;
  generate
    for (i = 1; i < DEPTH; i++) begin : g_link
      assign move[i]    = mark[i-1] & ~mark[i];
      assign feed[i]    = word[i-1];
      assign clear[i-1] = move[i];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      mark    <= '0;
      shin_q  <= 1'b0;
      shout_q <= 1'b0;
    end else begin
      shin_q  <= shin;
      shout_q <= shout;
      mark    <= (mark | move) & ~clear;
    end
    for (int s = 0; s < DEPTH; s++)
      if (move[s]) word[s] <= feed[s];
  end

  assign in_rdy  = ~mark[0];
  assign out_rdy = mark[LAST];
  assign dout_en = oe;
  assign dout    = oe ? word[LAST] : '0;
endmodule

// File: rtl/bubble_fifo_chk.sv
module bubble_fifo_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             shin,
  input logic             in_rdy,
  input logic             shout,
  input logic             oe,
  input logic [WIDTH-1:0] dout,
  input logic             out_rdy
);
  logic shin_p, shout_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      shin_p  <= 1'b0;
      shout_p <= 1'b0;
    end else begin
      shin_p  <= shin;
      shout_p <= shout;
    end
  end

  // R1
  reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (in_rdy && !out_rdy));

  // R3
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (shin && !shin_p && in_rdy) |=> !in_rdy);

  // R7
  pop_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (shout && !shout_p && out_rdy) |=> !out_rdy);

  // R5
  hold_word_chk: assert property (@(posedge clk) disable iff (rst)
    (out_rdy && !(shout && !shout_p) && oe && $past(oe)) |=> (out_rdy && $stable(dout)));

  // R9
  idle_out_chk: assert property (@(posedge clk) disable iff (rst)
    !oe |-> (dout == '0));
endmodule

bind bubble_fifo bubble_fifo_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .shin(shin), .in_rdy(in_rdy), .shout(shout),
  .oe(oe), .dout(dout), .out_rdy(out_rdy)
);

// File: tb/bubble_fifo_bench.sv
module bubble_fifo_bench;
  localparam int PERIOD = 10;
  localparam int NVEC = 8;
  // {din[3:0], oe, expected dout[3:0]}
  localparam logic [8:0] VEC [NVEC] = '{
    {4'h3, 1'b1, 4'h3}, {4'hA, 1'b1, 4'hA}, {4'h0, 1'b1, 4'h0}, {4'hF, 1'b0, 4'h0},
    {4'h5, 1'b1, 4'h5}, {4'hC, 1'b0, 4'h0}, {4'h9, 1'b1, 4'h9}, {4'h6, 1'b1, 4'h6}
  };

  logic clk = 0, rst = 1, shin = 0, shout = 0, oe = 1;
  logic [3:0] din = 0;
  logic in_rdy, out_rdy, dout_en;
  logic [3:0] dout;
  int checks = 0, errors = 0;

  always #(PERIOD/2) clk = ~clk;

  bubble_fifo u_bubble_fifo (
    .clk(clk), .rst(rst), .shin(shin), .din(din), .in_rdy(in_rdy),
    .shout(shout), .oe(oe), .dout(dout), .dout_en(dout_en), .out_rdy(out_rdy)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_in();
    for (int k = 0; k < 40 && !in_rdy; k++) @(negedge clk);
  endtask

  task automatic wait_out();
    for (int k = 0; k < 40 && !out_rdy; k++) @(negedge clk);
  endtask

  task automatic push(input logic [3:0] w);
    wait_in();
    din = w; shin = 1;
    @(negedge clk);
    shin = 0;
    @(negedge clk);
  endtask

  task automatic pop();
    shout = 1;
    @(negedge clk);
    chk("R7 out_rdy after pop", {7'b0, out_rdy}, 8'h0);
    shout = 0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1; cyc(2); rst = 0;
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3); rst = 0;
    chk("R1 in_rdy after reset", {7'b0, in_rdy}, 8'h1);
    chk("R1 out_rdy after reset", {7'b0, out_rdy}, 8'h0);

    // R3 and R4: single word into an empty buffer
    din = 4'h7; shin = 1;
    @(negedge clk);
    shin = 0;
    chk("R3 in_rdy low after accept", {7'b0, in_rdy}, 8'h0);
    @(negedge clk);
    chk("R3 in_rdy back after one cycle", {7'b0, in_rdy}, 8'h1);
    cyc(13);
    chk("R4 out_rdy not before 15 clocks", {7'b0, out_rdy}, 8'h0);
    @(negedge clk);
    chk("R4 out_rdy at 15 clocks", {7'b0, out_rdy}, 8'h1);
    chk("R9 dout word", {4'h0, dout}, 8'h07);
    oe = 0; #1;
    chk("R9 dout zero when disabled", {4'h0, dout}, 8'h00);
    chk("R9 dout_en low", {7'b0, dout_en}, 8'h0);
    oe = 1; #1;
    chk("R9 dout_en high", {7'b0, dout_en}, 8'h1);
    cyc(3);
    chk("R5 word held until popped", {3'b0, out_rdy, dout}, 8'h17);
    pop();
    cyc(20);
    chk("R7 empty after pop", {7'b0, out_rdy}, 8'h0);

    // table walk: order and output enable (R5, R9)
    for (int v = 0; v < NVEC; v++) push(VEC[v][8:5]);
    for (int v = 0; v < NVEC; v++) begin
      wait_out();
      oe = VEC[v][4]; #1;
      chk("R5/R9 table dout", {3'b0, out_rdy, dout}, {4'h1, VEC[v][3:0]});
      oe = 1;
      pop();
    end
    cyc(20);
    chk("R5 drained", {7'b0, out_rdy}, 8'h0);

    // R2: held strobe stores one word
    din = 4'hB; shin = 1; cyc(6); shin = 0;
    cyc(20);
    chk("R2 held shin word", {3'b0, out_rdy, dout}, 8'h1B);
    pop(); cyc(20);
    chk("R2 only one word stored", {7'b0, out_rdy}, 8'h0);

    // R8: pop edge on empty buffer
    shout = 1; @(negedge clk); shout = 0; @(negedge clk);
    chk("R8 out_rdy stays low", {7'b0, out_rdy}, 8'h0);
    push(4'h4); cyc(20);
    chk("R8 later word kept", {3'b0, out_rdy, dout}, 8'h14);
    pop(); cyc(5);

    // R6: fill, extra strobes ignored, drain
    for (int v = 0; v < 16; v++) push(4'(v));
    cyc(25);
    chk("R6 in_rdy low when full", {7'b0, in_rdy}, 8'h0);
    for (int k = 0; k < 3; k++) begin
      din = 4'hE; shin = 1; @(negedge clk); shin = 0; @(negedge clk);
    end
    chk("R6 in_rdy still low", {7'b0, in_rdy}, 8'h0);
    for (int v = 0; v < 16; v++) begin
      wait_out();
      chk("R6 drain word", {3'b0, out_rdy, dout}, {4'h1, 4'(v)});
      shout = 1; @(negedge clk); shout = 0; @(negedge clk);
      if (v < 15) chk("R7 refill one clock later", {7'b0, out_rdy}, 8'h1);
    end
    cyc(25);
    chk("R6 nothing extra stored", {7'b0, out_rdy}, 8'h0);

    // R10: reset discards held words
    for (int v = 0; v < 5; v++) push(4'h8);
    do_reset();
    chk("R10 in_rdy after reset", {7'b0, in_rdy}, 8'h1);
    chk("R10 out_rdy after reset", {7'b0, out_rdy}, 8'h0);
    cyc(25);
    chk("R10 no words survive", {7'b0, out_rdy}, 8'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule